// File: doc/BRIEF.md
# SECDED-Protected Streaming Data FIFO

A single-clock first-in first-out store for the data path of a card host controller. Every word goes into an inferred array together with check bits from an extended Hamming code. The code corrects any single flipped bit and detects any two flipped bits. Data enters through a push/pop streaming interface. A separate direct write window lets software load any location by address. It is meant for clearing the whole array to zero before checking is switched on, because locations that were never written would otherwise report false errors.

A small control state machine owns the pointers and the occupancy counter. It has two states. `ST_RUN` is normal streaming. `ST_FLUSH` is a one-cycle clearing state. Transition `RUN_TO_FLUSH` is taken when `fifo_rst_req` is seen in `ST_RUN`. Transition `FLUSH_TO_RUN` is always taken on the next edge, and on that edge the pointers, the counter and the overflow/underflow flags are zeroed. The `fifo_rst_busy` output is the request bit that clears itself: it is high for exactly the one `ST_FLUSH` cycle. The array contents are left untouched. Corrected and uncorrectable read errors are held in two separate sticky flags, each with its own write-1-to-clear input.

An `inj_mask` input is XORed into the codeword stored on a push. This lets every error position be exercised from the ports.

Top module: `ecc_data_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0, `pop_valid`=0, `fifo_rst_busy`=0, and `sb_err`, `db_err`, `ovf`, `udf` are all 0.
- R2: A pop accepted on an edge gives `pop_valid`=1 in the following cycle, with the oldest unread word on `pop_data`. Words come out in push order.
- R3: `level` counts the stored words, with `empty` = (`level`==0) and `full` = (`level`==DEPTH). A push and a pop in the same cycle with the FIFO neither empty nor full leave `level` unchanged.
- R4: A push while `full` changes neither the contents nor `level`, and sets the sticky `ovf` flag.
- R5: A pop while `empty` gives no `pop_valid`, leaves `level` at 0, and sets the sticky `udf` flag.
- R6: A window write to byte offset WIN_BASE + 4·n (n < DEPTH) stores `win_wdata` into word n with freshly computed check bits. Offsets below WIN_BASE, at or beyond WIN_BASE + 4·DEPTH, or not a multiple of 4 are ignored.
- R7: A `fifo_rst_req` seen in `ST_RUN` makes `fifo_rst_busy` high for exactly one cycle. After that cycle, `level`=0, `empty`=1 and `ovf`=`udf`=0. Pushes and pops during the busy cycle are ignored.
- R8: Codeword layout (DW=32, 39 bits): bit 0 is the overall parity. Bit k (1..38) is Hamming position k. Check bits sit at the power-of-two positions. Data bits fill the remaining positions in ascending order, so data bit 0 is at position 3. On a push, `inj_mask` is XORed into the stored codeword.
- R9: With `ecc_en`=1, a word read with exactly one flipped codeword bit comes out corrected, and `sb_err` is set one cycle after `pop_valid`.
- R10: With `ecc_en`=1, a word read with exactly two flipped bits comes out as the raw stored data bits. `db_err` is set and `sb_err` is not.
- R11: With `ecc_en`=0, `pop_data` is the raw stored data bits and neither error flag is set.
- R12: A 1 on `sb_clr` (or `db_clr`) clears its flag on the next edge. A new error that sets the flag on that same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write `push_data` into the FIFO |
| push_data | input | DW | Data to push |
| inj_mask | input | DW+CB+1 | Bits flipped in the stored codeword on a push |
| pop | input | 1 | Read the oldest word |
| pop_valid | output | 1 | `pop_data` holds a popped word this cycle |
| pop_data | output | DW | Popped word after decoding |
| win_we | input | 1 | Direct window write strobe |
| win_addr | input | AW | Byte offset of the window write |
| win_wdata | input | DW | Window write data |
| ecc_en | input | 1 | Enable correction and error reporting |
| fifo_rst_req | input | 1 | Request a pointer/counter clear |
| fifo_rst_busy | output | 1 | Clear in progress; drops by itself |
| level | output | $clog2(DEPTH)+1 | Stored word count |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| sb_err | output | 1 | Sticky corrected-error flag |
| db_err | output | 1 | Sticky uncorrectable-error flag |
| sb_clr | input | 1 | Write-1-to-clear for `sb_err` |
| db_clr | input | 1 | Write-1-to-clear for `db_err` |
| ovf | output | 1 | Sticky push-while-full flag |
| udf | output | 1 | Sticky pop-while-empty flag |

## Verification
The bench builds the block with DEPTH=8, a 10-bit window address and the window at 0x200. Data stays at 32 bits, so the codeword keeps its real 39-bit shape. The small depth makes filling, overflow, wrap-around and every window slot cheap to reach, and the first address past the window aliases slot 0 under index truncation. Against this, every single-bit flip position and every adjacent pair of flips is swept with checking on and off, and the expected data is computed from the position map.

// File: rtl/ecc_fifo_pkg.sv
package ecc_fifo_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } fifo_state_e;

    function automatic int check_bits(input int dw);
        int c;
        c = 0;
        while ((1 << c) < dw + c + 1) c++;
        return c;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
    parameter int DW = 32,
    localparam int CB = ecc_fifo_pkg::check_bits(DW),
    localparam int N  = DW + CB,
    localparam int CW = N + 1
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] cw
);
    logic [N:1] pos;
    int         d;

    always_comb begin
        pos = '0;
        d   = 0;
        for (int j = 1; j <= N; j++) begin
            if (!ecc_fifo_pkg::is_pow2(j)) begin
                pos[j] = data[d];
                d++;
            end
        end
        for (int i = 0; i < CB; i++) begin
            for (int j = 1; j <= N; j++) begin
                if (((j >> i) & 1) == 1 && j != (1 << i)) pos[1 << i] = pos[1 << i] ^ pos[j];
            end
        end
        cw = {pos, ^pos};
    end

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
    parameter int DW = 32,
    localparam int CB = ecc_fifo_pkg::check_bits(DW),
    localparam int N  = DW + CB,
    localparam int CW = N + 1
) (
    input  logic [CW-1:0] cw,
    input  logic          ecc_en,
    output logic [DW-1:0] data,
    output logic          sb_hit,
    output logic          db_hit
);
    logic [CB-1:0] syn;
    logic          par;
    logic [CW-1:0] fixed;
    int            d;

    always_comb begin
        syn = '0;
        for (int j = 1; j <= N; j++) begin
            if (cw[j]) syn = syn ^ CB'(j);
        end
        par    = ^cw;
        fixed  = cw;
        sb_hit = 1'b0;
        db_hit = 1'b0;
        if (ecc_en) begin
            if (par) begin
                sb_hit = 1'b1;
                for (int j = 1; j <= N; j++) begin
                    if (CB'(j) == syn) fixed[j] = ~fixed[j];
                end
            end else if (syn != '0) begin
                db_hit = 1'b1;
            end
        end
        data = '0;
        d    = 0;
        for (int j = 1; j <= N; j++) begin
            if (!ecc_fifo_pkg::is_pow2(j)) begin
                data[d] = fixed[j];
                d++;
            end
        end
    end

endmodule

// File: rtl/ecc_fifo_ctrl.sv
module ecc_fifo_ctrl #(
    parameter int DEPTH = 1024,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            flush_req,
    output logic            wr_go,
    output logic [PTRW-1:0] wr_ptr,
    output logic            rd_go,
    output logic [PTRW-1:0] rd_ptr,
    output logic [CNTW-1:0] level,
    output logic            empty,
    output logic            full,
    output logic            ovf,
    output logic            udf,
    output logic            busy
);
    import ecc_fifo_pkg::*;

    fifo_state_e state, state_nx;
    logic [CNTW-1:0] count;
    logic            run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (flush_req) state_nx = ST_FLUSH;  // RUN_TO_FLUSH
            ST_FLUSH: state_nx = ST_RUN;                   // FLUSH_TO_RUN
            default:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        run   = (state == ST_RUN);
        busy  = (state == ST_FLUSH);
        empty = (count == '0);
        full  = (count == CNTW'(DEPTH));
        level = count;
        wr_go = run && push && !full;
        rd_go = run && pop && !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else if (busy) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            udf    <= 1'b0;
        end else begin
            if (wr_go) wr_ptr <= wr_ptr + 1'b1;
            if (rd_go) rd_ptr <= rd_ptr + 1'b1;
            if (wr_go && !rd_go)      count <= count + 1'b1;
            else if (rd_go && !wr_go) count <= count - 1'b1;
            if (push && full) ovf <= 1'b1;
            if (pop && empty) udf <= 1'b1;
        end
    end

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNTW'(DEPTH)); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !busy && !flush_req |=> full && ovf); // R4
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !busy && !flush_req |=> empty && udf); // R5
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R7
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> empty && !ovf && !udf); // R7

endmodule

// File: rtl/ecc_data_fifo.sv
module ecc_data_fifo #(
    parameter int             DEPTH    = 1024,
    parameter int             DW       = 32,
    parameter int             AW       = 13,
    parameter logic [AW-1:0]  WIN_BASE = AW'(12'h200),
    localparam int CB   = ecc_fifo_pkg::check_bits(DW),
    localparam int CW   = DW + CB + 1,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic [CW-1:0]   inj_mask,
    input  logic            pop,
    output logic            pop_valid,
    output logic [DW-1:0]   pop_data,
    input  logic            win_we,
    input  logic [AW-1:0]   win_addr,
    input  logic [DW-1:0]   win_wdata,
    input  logic            ecc_en,
    input  logic            fifo_rst_req,
    output logic            fifo_rst_busy,
    output logic [CNTW-1:0] level,
    output logic            empty,
    output logic            full,
    output logic            sb_err,
    output logic            db_err,
    input  logic            sb_clr,
    input  logic            db_clr,
    output logic            ovf,
    output logic            udf
);
    localparam int WIN_SPAN = 4 * DEPTH;

    logic [CW-1:0]   mem [DEPTH];
    logic            wr_go, rd_go;
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0]   push_cw, win_cw, rd_cw;
    logic [AW-1:0]   win_off;
    logic            win_ok;
    logic [PTRW-1:0] win_idx;
    logic            sb_hit, db_hit;

    ecc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush_req(fifo_rst_req),
        .wr_go(wr_go), .wr_ptr(wr_ptr), .rd_go(rd_go), .rd_ptr(rd_ptr),
        .level(level), .empty(empty), .full(full), .ovf(ovf), .udf(udf),
        .busy(fifo_rst_busy)
    );

    ecc_secded_enc #(.DW(DW)) u_enc_push (.data(push_data), .cw(push_cw));
    ecc_secded_enc #(.DW(DW)) u_enc_win  (.data(win_wdata), .cw(win_cw));

    always_comb begin
        win_off = win_addr - WIN_BASE;
        win_ok  = win_we && (win_addr >= WIN_BASE) && (int'(win_off) < WIN_SPAN)
                  && (win_off[1:0] == 2'b00);
        win_idx = win_off[PTRW+1:2];
    end

    // push is applied after the window so it wins on a same-slot collision
    always_ff @(posedge clk) begin
        if (win_ok) mem[win_idx] <= win_cw;
        if (wr_go)  mem[wr_ptr]  <= push_cw ^ inj_mask;
    end

    always_ff @(posedge clk) begin
        if (rd_go) rd_cw <= mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pop_valid <= 1'b0;
        else        pop_valid <= rd_go;
    end

    ecc_secded_dec #(.DW(DW)) u_dec (
        .cw(rd_cw), .ecc_en(ecc_en), .data(pop_data), .sb_hit(sb_hit), .db_hit(db_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_err <= 1'b0;
            db_err <= 1'b0;
        end else begin
            sb_err <= (sb_err && !sb_clr) || (pop_valid && sb_hit);
            db_err <= (db_err && !db_clr) || (pop_valid && db_hit);
        end
    end

    AST_POP_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !empty && !fifo_rst_busy |=> pop_valid); // R2
    AST_NO_VALID_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty |=> !pop_valid); // R5
    AST_SB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sb_err && !sb_clr |=> sb_err); // R12
    AST_DB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        db_err && !db_clr |=> db_err); // R12
    AST_OFF_NO_NEW_SB: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en && !sb_err |=> !sb_err); // R11

endmodule

// File: tb/ecc_data_fifo_bench.sv
module ecc_data_fifo_bench;
    localparam int DEPTH = 8;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int CW    = 39;
    localparam int CNTW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push = 0, pop = 0, win_we = 0, ecc_en = 0, fifo_rst_req = 0, sb_clr = 0, db_clr = 0;
    logic [DW-1:0] push_data = '0, win_wdata = '0;
    logic [CW-1:0] inj_mask = '0;
    logic [AW-1:0] win_addr = '0;
    logic pop_valid, fifo_rst_busy, empty, full, sb_err, db_err, ovf, udf;
    logic [DW-1:0] pop_data;
    logic [CNTW-1:0] level;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ecc_data_fifo #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .WIN_BASE(10'h200)) u_ecc_data_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .inj_mask(inj_mask),
        .pop(pop), .pop_valid(pop_valid), .pop_data(pop_data), .win_we(win_we),
        .win_addr(win_addr), .win_wdata(win_wdata), .ecc_en(ecc_en),
        .fifo_rst_req(fifo_rst_req), .fifo_rst_busy(fifo_rst_busy), .level(level),
        .empty(empty), .full(full), .sb_err(sb_err), .db_err(db_err), .sb_clr(sb_clr),
        .db_clr(db_clr), .ovf(ovf), .udf(udf)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return 32'hA5C3_0F00 ^ (32'h0101_0101 * (i + 1));
    endfunction

    function automatic bit pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // R8: data bit index held at codeword bit k, or -1 for check/parity bits
    function automatic int dbit(input int k);
        int p;
        if (k == 0 || pow2(k)) return -1;
        p = 0;
        while ((1 << p) <= k) p++;
        return k - p - 1;
    endfunction

    function automatic logic [DW-1:0] raw(input logic [DW-1:0] d, input logic [CW-1:0] m);
        logic [DW-1:0] r;
        r = d;
        for (int k = 1; k < CW; k++) if (m[k] && dbit(k) >= 0) r[dbit(k)] = ~r[dbit(k)];
        return r;
    endfunction

    task automatic do_push(input logic [DW-1:0] d, input logic [CW-1:0] m);
        push = 1; push_data = d; inj_mask = m;
        step();
        push = 0; inj_mask = '0;
    endtask

    task automatic do_pop(input string req, input logic [DW-1:0] exp);
        pop = 1;
        step();
        pop = 0;
        check(req, pop_valid, 1'b1);
        check(req, pop_data, exp);
    endtask

    task automatic do_flush();
        fifo_rst_req = 1;
        step();
        fifo_rst_req = 0;
        step();
    endtask

    task automatic win_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        win_we = 1; win_addr = a; win_wdata = d;
        step();
        win_we = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #5;
        // R1 reset state
        check("R1 empty", empty, 1); check("R1 full", full, 0); check("R1 level", level, 0);
        check("R1 pop_valid", pop_valid, 0); check("R1 busy", fifo_rst_busy, 0);
        check("R1 flags", {sb_err, db_err, ovf, udf}, 4'h0);

        // R3 fill sweep
        for (int i = 0; i < DEPTH; i++) begin
            do_push(pat(i), '0);
            check("R3 level fill", level, i + 1);
            check("R3 full", full, (i == DEPTH - 1));
            check("R3 empty", empty, 0);
        end
        // R4 push when full
        do_push(32'hDEAD_BEEF, '0);
        check("R4 level", level, DEPTH); check("R4 ovf", ovf, 1);
        // R2 drain in order
        for (int i = 0; i < DEPTH; i++) begin
            do_pop("R2 order", pat(i));
            check("R3 level drain", level, DEPTH - 1 - i);
        end
        // R5 pop when empty
        pop = 1; step(); pop = 0;
        check("R5 no valid", pop_valid, 0); check("R5 udf", udf, 1); check("R5 level", level, 0);

        // R7 flush with push attempted in busy cycle
        do_push(pat(20), '0); do_push(pat(21), '0); do_push(pat(22), '0);
        fifo_rst_req = 1; step(); fifo_rst_req = 0;
        check("R7 busy high", fifo_rst_busy, 1);
        push = 1; push_data = pat(23); step(); push = 0;
        check("R7 busy low", fifo_rst_busy, 0);
        check("R7 level", level, 0); check("R7 empty", empty, 1);
        check("R7 ovf/udf", {ovf, udf}, 2'b00);

        // R3 simultaneous push and pop
        do_push(pat(30), '0); do_push(pat(31), '0);
        push = 1; push_data = pat(32); pop = 1; step(); push = 0; pop = 0;
        check("R3 simul level", level, 2);
        check("R2 simul valid", pop_valid, 1); check("R2 simul data", pop_data, pat(30));
        do_pop("R2 after simul", pat(31)); do_pop("R2 after simul", pat(32));
        do_flush();

        // R6 window writes, ECC on, pointers at 0
        ecc_en = 1;
        for (int i = 0; i < DEPTH; i++) do_push(pat(40 + i), '0);
        win_write(10'h208, 32'h1234_5678);
        win_write(10'h220, 32'hBAD0_0000);
        win_write(10'h1FC, 32'hBAD0_0001);
        win_write(10'h205, 32'hBAD0_0002);
        for (int i = 0; i < DEPTH; i++)
            do_pop("R6 window", (i == 2) ? 32'h1234_5678 : pat(40 + i));
        step();
        check("R6 no ecc error", {sb_err, db_err}, 2'b00);

        // R9 single-bit sweep, ECC on
        for (int k = 0; k < CW; k++) begin
            do_push(pat(k), CW'(1) << k);
            do_pop("R9 corrected", pat(k));
            step();
            check("R9 sb set", sb_err, 1); check("R10 db clear", db_err, 0);
            sb_clr = 1; step(); sb_clr = 0;
            check("R12 sb clr", sb_err, 0);
        end
        // R10 adjacent-pair sweep, ECC on
        for (int k = 0; k < CW - 1; k++) begin
            do_push(pat(k), (CW'(3) << k));
            do_pop("R10 raw", raw(pat(k), CW'(3) << k));
            step();
            check("R10 db set", db_err, 1); check("R10 sb clear", sb_err, 0);
            db_clr = 1; step(); db_clr = 0;
            check("R12 db clr", db_err, 0);
        end
        // R11 ECC off, single flips pass raw
        ecc_en = 0;
        for (int k = 0; k < CW; k++) begin
            do_push(pat(k + 7), CW'(1) << k);
            do_pop("R11 raw", raw(pat(k + 7), CW'(1) << k));
            step();
            check("R11 no flags", {sb_err, db_err}, 2'b00);
        end
        // R12 set wins over clear on the same edge
        ecc_en = 1;
        do_push(pat(99), CW'(1) << 9);
        do_pop("R9 corrected", pat(99));
        sb_clr = 1; step(); sb_clr = 0;
        check("R12 set wins", sb_err, 1);
        sb_clr = 1; step(); sb_clr = 0;
        check("R12 cleared", sb_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule